// File: doc/BRIEF.md
# Section TLB with Lockable Side Entries

This block caches virtual-to-physical translations for 1 MiB sections of a 32-bit address space. Two arrays are searched side by side in a single cycle. One is a two-way set associative main array. The other is a side array of four fully associative entries. When a lookup hits, a response is returned one cycle after the request is accepted. The response carries the physical address, which is the cached section base followed by the untouched low 20 address bits, together with a 2-bit access-permission field and a fault flag.

When both arrays miss, the block stops accepting lookups. It raises a single request on an external page-walk port and waits for the answer. The returned translation is installed in the main array only, and it is also returned as the response. A control port lets software load any side entry directly, set or clear that entry's lock bit, and invalidate the whole buffer. A locked side entry keeps mapping its region through any amount of refill traffic and through a global invalidate. This guarantees that the latency-critical regions never miss.

Top module: `tlb_lockable`

## Requirements
- R1: After reset no entry is valid: `lk_ready` is 1, `rsp_valid`, `walk_req_valid` and `walk_rsp_ready` are 0, and the first lookup of any address misses.
- R2: A lookup accepted when `lk_valid` and `lk_ready` are both 1 and that hits returns `rsp_valid`=1, `rsp_hit`=1 on the next cycle. It returns `rsp_paddr` = {cached section base, `lk_vaddr[19:0]`} and `rsp_perm` = the cached permission.
- R3: A lookup that misses in both arrays raises `walk_req_valid` with `walk_req_vpn` = `lk_vaddr[31:20]`. The request is held stable until `walk_req_ready`. `lk_ready` stays 0 until the walk response is taken, and only one walk is outstanding.
- R4: A walk response taken while `walk_rsp_ready`=1 gives `rsp_valid`=1, `rsp_hit`=0 on the next cycle, carrying {`walk_rsp_pbase`, offset} and `walk_rsp_perm`. The translation is written into the main array, so a repeat lookup of that section hits.
- R5: The main-array set is `vpn[SET_W-1:0]`, where vpn = `lk_vaddr[31:20]`. A refill takes way 0 if it is invalid, else way 1 if it is invalid, else the set's round-robin way. After each refill the round-robin bit of that set points at the other way.
- R6: Control op 0 (write) loads side entry `ctl_idx` with `ctl_vpn`, `ctl_pbase` and `ctl_perm`, and marks it valid. Later lookups of that section hit with that translation and raise no walk.
- R7: When the side array and the main array both hit, the side entry's translation is returned. Among side entries, the lowest index wins.
- R8: A refill never writes a side entry, whether that entry is locked or unlocked. Side entries keep hitting after conflicting refills in the set they map to.
- R9: Control op 1 sets and op 2 clears the lock bit of entry `ctl_idx`. Op 3 invalidates every main-array entry and every unlocked side entry, while locked side entries keep their contents.
- R10: The fault flag depends on the permission code. Code 00 always faults. Code 01 faults when `lk_user`=1. Code 10 faults when `lk_user`=1 and `lk_write`=1. Code 11 never faults. The flag is evaluated on hit responses and on walk-fill responses alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Block idle, lookup can be accepted |
| lk_vaddr | input | 32 | Virtual address |
| lk_user | input | 1 | Request is unprivileged |
| lk_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | 1 = served from a cached entry, 0 = served by a walk |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 2 | Permission code of the translation |
| rsp_fault | output | 1 | Permission violation |
| walk_req_valid | output | 1 | Walk request |
| walk_req_ready | input | 1 | Walker accepts request |
| walk_req_vpn | output | 12 | Section number to walk |
| walk_rsp_valid | input | 1 | Walk result |
| walk_rsp_ready | output | 1 | Block waits for the walk result |
| walk_rsp_pbase | input | 12 | Returned physical section base |
| walk_rsp_perm | input | 2 | Returned permission code |
| ctl_valid | input | 1 | Control operation strobe |
| ctl_op | input | 2 | 0 write, 1 lock, 2 unlock, 3 invalidate all |
| ctl_idx | input | 2 | Side entry index |
| ctl_vpn | input | 12 | Section number for write |
| ctl_pbase | input | 12 | Physical section base for write |
| ctl_perm | input | 2 | Permission code for write |

## Verification
The bench builds the block with the default of 64 main entries, which gives 32 sets indexed by vpn[4:0]. Section numbers that differ only above bit 4, such as 0x003, 0x023 and 0x043, then collide in one set. Three of them are enough to show invalid-way-first filling and round-robin eviction. The same size lets a short burst of refills thrash the set that a locked side entry maps to, so that the lock's survival can be seen. The walker model delays both handshakes, which exposes the stall and the request hold.

// File: rtl/tlb_lockable.sv
module tlb_lockable #(
  parameter int MAIN_ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_vaddr,
  input  logic        lk_user,
  input  logic        lk_write,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [31:0] rsp_paddr,
  output logic [1:0]  rsp_perm,
  output logic        rsp_fault,
  output logic        walk_req_valid,
  input  logic        walk_req_ready,
  output logic [11:0] walk_req_vpn,
  input  logic        walk_rsp_valid,
  output logic        walk_rsp_ready,
  input  logic [11:0] walk_rsp_pbase,
  input  logic [1:0]  walk_rsp_perm,
  input  logic        ctl_valid,
  input  logic [1:0]  ctl_op,
  input  logic [1:0]  ctl_idx,
  input  logic [11:0] ctl_vpn,
  input  logic [11:0] ctl_pbase,
  input  logic [1:0]  ctl_perm
);
  localparam int SETS  = MAIN_ENTRIES / 2;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = 12 - SET_W;
  localparam int LK_N  = 4;
  localparam logic [1:0] OP_WRITE  = 2'd0;
  localparam logic [1:0] OP_LOCK   = 2'd1;
  localparam logic [1:0] OP_UNLOCK = 2'd2;
  localparam logic [1:0] OP_INVAL  = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

  function automatic logic perm_fault(input logic [1:0] p, input logic u, input logic w);
    case (p)
      2'b00:   perm_fault = 1'b1;
      2'b01:   perm_fault = u;
      2'b10:   perm_fault = u & w;
      default: perm_fault = 1'b0;
    endcase
  endfunction

  st_e st;

  logic [11:0] q_vpn;
  logic [19:0] q_off;
  logic        q_user, q_write;

  logic             m_v   [0:1][0:SETS-1];
  logic [TAG_W-1:0] m_tag [0:1][0:SETS-1];
  logic [11:0]      m_pb  [0:1][0:SETS-1];
  logic [1:0]       m_pm  [0:1][0:SETS-1];
  logic [SETS-1:0]  rr;

  logic [LK_N-1:0] x_v, x_lock;
  logic [11:0]     x_vpn [0:LK_N-1];
  logic [11:0]     x_pb  [0:LK_N-1];
  logic [1:0]      x_pm  [0:LK_N-1];

  wire [11:0]      l_vpn = lk_vaddr[31:20];
  wire [SET_W-1:0] l_set = l_vpn[SET_W-1:0];
  wire [TAG_W-1:0] l_tag = l_vpn[11 -: TAG_W];

  logic [1:0]      m_hit;
  logic [LK_N-1:0] x_hit;
  logic [11:0]     sel_pb;
  logic [1:0]      sel_pm;
  logic            l_hit;

  always_comb begin
    for (int w = 0; w < 2; w++)
      m_hit[w] = m_v[w][l_set] && (m_tag[w][l_set] == l_tag);
    for (int i = 0; i < LK_N; i++)
      x_hit[i] = x_v[i] && (x_vpn[i] == l_vpn);
  end

  always_comb begin
    sel_pb = '0;
    sel_pm = '0;
    if (m_hit[1]) begin sel_pb = m_pb[1][l_set]; sel_pm = m_pm[1][l_set]; end
    if (m_hit[0]) begin sel_pb = m_pb[0][l_set]; sel_pm = m_pm[0][l_set]; end
    for (int i = LK_N - 1; i >= 0; i--)
      if (x_hit[i]) begin sel_pb = x_pb[i]; sel_pm = x_pm[i]; end
  end

  assign l_hit = (|m_hit) | (|x_hit);

  assign lk_ready       = (st == S_IDLE);
  assign walk_req_valid = (st == S_REQ);
  assign walk_rsp_ready = (st == S_WAIT);
  assign walk_req_vpn   = q_vpn;

  wire             accept = lk_valid && lk_ready;
  wire             fill   = walk_rsp_ready && walk_rsp_valid;
  wire [SET_W-1:0] f_set  = q_vpn[SET_W-1:0];
  wire [TAG_W-1:0] f_tag  = q_vpn[11 -: TAG_W];
  wire             f_way  = !m_v[0][f_set] ? 1'b0 : (!m_v[1][f_set] ? 1'b1 : rr[f_set]);
  wire             c_inv  = ctl_valid && (ctl_op == OP_INVAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_fault <= 1'b0;
      q_vpn     <= '0;
      q_off     <= '0;
      q_user    <= 1'b0;
      q_write   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          q_vpn   <= l_vpn;
          q_off   <= lk_vaddr[19:0];
          q_user  <= lk_user;
          q_write <= lk_write;
          if (l_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_paddr <= {sel_pb, lk_vaddr[19:0]};
            rsp_perm  <= sel_pm;
            rsp_fault <= perm_fault(sel_pm, lk_user, lk_write);
          end else begin
            st <= S_REQ;
          end
        end
        S_REQ: if (walk_req_ready) st <= S_WAIT;
        S_WAIT: if (walk_rsp_valid) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_paddr <= {walk_rsp_pbase, q_off};
          rsp_perm  <= walk_rsp_perm;
          rsp_fault <= perm_fault(walk_rsp_perm, q_user, q_write);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr <= '0;
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < SETS; s++) m_v[w][s] <= 1'b0;
    end else begin
      if (c_inv)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < SETS; s++) m_v[w][s] <= 1'b0;
      if (fill) begin
        m_v[f_way][f_set] <= 1'b1;
        rr[f_set]         <= ~f_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      m_tag[f_way][f_set] <= f_tag;
      m_pb[f_way][f_set]  <= walk_rsp_pbase;
      m_pm[f_way][f_set]  <= walk_rsp_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_v    <= '0;
      x_lock <= '0;
      for (int i = 0; i < LK_N; i++) begin
        x_vpn[i] <= '0;
        x_pb[i]  <= '0;
        x_pm[i]  <= '0;
      end
    end else if (ctl_valid) begin
      case (ctl_op)
        OP_WRITE: begin
          x_v[ctl_idx]   <= 1'b1;
          x_vpn[ctl_idx] <= ctl_vpn;
          x_pb[ctl_idx]  <= ctl_pbase;
          x_pm[ctl_idx]  <= ctl_perm;
        end
        OP_LOCK:   x_lock[ctl_idx] <= 1'b1;
        OP_UNLOCK: x_lock[ctl_idx] <= 1'b0;
        default:   x_v <= x_v & x_lock;
      endcase
    end
  end
endmodule

// File: rtl/tlb_lockable_chk.sv
module tlb_lockable_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic [31:0] lk_vaddr,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [31:0] rsp_paddr,
  input logic [1:0]  rsp_perm,
  input logic        rsp_fault,
  input logic        walk_req_valid,
  input logic        walk_req_ready,
  input logic [11:0] walk_req_vpn,
  input logic        walk_rsp_valid,
  input logic        walk_rsp_ready,
  input logic        ctl_valid,
  input logic [1:0]  ctl_op,
  input logic [1:0]  ctl_idx,
  input logic [3:0]  x_v,
  input logic [3:0]  x_lock
);
  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> $past(lk_valid && lk_ready));

  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_paddr[19:0] == $past(lk_vaddr[19:0]));

  p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_req_vpn));

  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !lk_ready);

  p_one_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_ready |-> !walk_req_valid && !lk_ready);

  p_fill_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid && walk_rsp_ready |=> rsp_valid && !rsp_hit);

  p_noaccess_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_perm == 2'b00 |-> rsp_fault);

  p_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_perm == 2'b11 |-> !rsp_fault);

  for (genvar i = 0; i < 4; i++) begin : g_lk
    p_locked_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      x_lock[i] && x_v[i] && !(ctl_valid && ctl_op == 2'd2 && ctl_idx == 2'(i)) |=> x_v[i]);
  end
endmodule

bind tlb_lockable tlb_lockable_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
  .rsp_fault(rsp_fault), .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
  .walk_req_vpn(walk_req_vpn), .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ready(walk_rsp_ready),
  .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_idx(ctl_idx), .x_v(x_v), .x_lock(x_lock)
);

// File: tb/tlb_lockable_tb.sv
`timescale 1ns/1ps
module tlb_lockable_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        lk_valid = 0, lk_user = 0, lk_write = 0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_ready;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_perm;
  logic        walk_req_valid, walk_rsp_ready;
  logic        walk_req_ready = 0, walk_rsp_valid = 0;
  logic [11:0] walk_req_vpn;
  logic [11:0] walk_rsp_pbase = '0;
  logic [1:0]  walk_rsp_perm = 2'b11;
  logic        ctl_valid = 0;
  logic [1:0]  ctl_op = '0, ctl_idx = '0, ctl_perm = '0;
  logic [11:0] ctl_vpn = '0, ctl_pbase = '0;

  tlb_lockable #(.MAIN_ENTRIES(64)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0]  walk_perm = 2'b11;
  logic [11:0] last_vpn = '0;

  typedef struct {
    logic hit; logic [31:0] pa; logic [1:0] perm; logic fault; string tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [11:0] wmap(input logic [11:0] v);
    return v + 12'h100;
  endfunction

  // driver: pushes expectation, then presents the lookup
  task automatic lookup(input logic [31:0] va, input bit u, input bit w, input bit ehit,
                        input logic [11:0] epb, input logic [1:0] eperm, input bit efault,
                        input string tag);
    exp_t e;
    while (!lk_ready) @(negedge clk);
    e.hit = ehit; e.pa = {epb, va[19:0]}; e.perm = eperm; e.fault = efault; e.tag = tag;
    exp_q.push_back(e);
    last_vpn = va[31:20];
    lk_valid = 1; lk_vaddr = va; lk_user = u; lk_write = w;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !lk_ready) @(negedge clk);
  endtask

  task automatic ctl(input logic [1:0] op, input logic [1:0] idx, input logic [11:0] vpn,
                     input logic [11:0] pb, input logic [1:0] pm);
    drain();
    ctl_valid = 1; ctl_op = op; ctl_idx = idx; ctl_vpn = vpn; ctl_pbase = pb; ctl_perm = pm;
    @(negedge clk);
    ctl_valid = 0;
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_hit == e.hit, {e.tag, " hit"}, rsp_hit, e.hit);
        chk(rsp_paddr == e.pa, {e.tag, " paddr"}, rsp_paddr, e.pa);
        chk(rsp_perm == e.perm, {e.tag, " perm"}, rsp_perm, e.perm);
        chk(rsp_fault == e.fault, {e.tag, " fault"}, rsp_fault, e.fault);
      end
    end
  end

  // walker model with delayed handshakes
  initial forever begin
    logic [11:0] got;
    @(negedge clk);
    if (rst_n && walk_req_valid) begin
      repeat (2) @(negedge clk);
      chk(walk_req_valid == 1'b1, "R3 request held", walk_req_valid, 1);
      got = walk_req_vpn;
      chk(got == last_vpn, "R3 walk vpn", got, last_vpn);
      walk_req_ready = 1;
      @(negedge clk);
      walk_req_ready = 0;
      repeat (6) @(negedge clk);
      chk(lk_ready == 1'b0, "R3 stall during walk", lk_ready, 0);
      walk_rsp_valid = 1; walk_rsp_pbase = wmap(got); walk_rsp_perm = walk_perm;
      @(negedge clk);
      walk_rsp_valid = 0;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(lk_ready == 1, "R1 lk_ready", lk_ready, 1);
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    chk(walk_req_valid == 0, "R1 walk_req_valid", walk_req_valid, 0);
    chk(walk_rsp_ready == 0, "R1 walk_rsp_ready", walk_rsp_ready, 0);

    // R1 R4: first access misses, then hits with the same translation (R2)
    lookup(32'h1234_5678, 0, 0, 0, 12'h223, 2'b11, 0, "R1 first miss");
    lookup(32'h1234_5678, 0, 0, 1, 12'h223, 2'b11, 0, "R4 hit after fill");
    lookup(32'h123F_FFFF, 0, 1, 1, 12'h223, 2'b11, 0, "R2 offset pass");

    // R5: set 3 collisions, invalid first then round robin
    lookup(32'h0030_0010, 0, 0, 0, 12'h103, 2'b11, 0, "R5 A fill way0");
    lookup(32'h0230_0020, 0, 0, 0, 12'h123, 2'b11, 0, "R5 B fill way1");
    lookup(32'h0430_0030, 0, 0, 0, 12'h143, 2'b11, 0, "R5 C evicts A");
    lookup(32'h0230_0040, 0, 0, 1, 12'h123, 2'b11, 0, "R5 B still hit");
    lookup(32'h0030_0050, 0, 0, 0, 12'h103, 2'b11, 0, "R5 A misses, evicts B");
    lookup(32'h0430_0060, 0, 0, 1, 12'h143, 2'b11, 0, "R5 C still hit");
    lookup(32'h0230_0070, 0, 0, 0, 12'h123, 2'b11, 0, "R5 B misses");

    // R6: side entry write
    ctl(2'd0, 2'd0, 12'h555, 12'h0AB, 2'b11);
    lookup(32'h555A_BCDE, 0, 0, 1, 12'h0AB, 2'b11, 0, "R6 side hit");

    // R7: side entry beats main array
    lookup(32'h6000_0004, 0, 0, 0, 12'h700, 2'b11, 0, "R7 main fill");
    ctl(2'd0, 2'd1, 12'h600, 12'h0CD, 2'b11);
    lookup(32'h6000_0004, 0, 0, 1, 12'h0CD, 2'b11, 0, "R7 side priority");

    // R8: refills into set 0x15 leave side entries alone
    ctl(2'd1, 2'd0, 12'h000, 12'h000, 2'b00);
    lookup(32'h0150_0000, 0, 0, 0, 12'h115, 2'b11, 0, "R8 thrash 1");
    lookup(32'h0350_0000, 0, 0, 0, 12'h135, 2'b11, 0, "R8 thrash 2");
    lookup(32'h0750_0000, 0, 0, 0, 12'h175, 2'b11, 0, "R8 thrash 3");
    lookup(32'h5550_0100, 0, 0, 1, 12'h0AB, 2'b11, 0, "R8 locked side kept");
    lookup(32'h6000_0200, 0, 0, 1, 12'h0CD, 2'b11, 0, "R8 unlocked side kept");

    // R9: invalidate keeps locked, drops unlocked and main
    ctl(2'd3, 2'd0, 12'h000, 12'h000, 2'b00);
    lookup(32'h5550_0300, 0, 0, 1, 12'h0AB, 2'b11, 0, "R9 locked survives");
    lookup(32'h6000_0400, 0, 0, 0, 12'h700, 2'b11, 0, "R9 unlocked dropped");
    lookup(32'h1230_0000, 0, 0, 0, 12'h223, 2'b11, 0, "R9 main dropped");
    ctl(2'd2, 2'd0, 12'h000, 12'h000, 2'b00);
    ctl(2'd3, 2'd0, 12'h000, 12'h000, 2'b00);
    lookup(32'h5550_0500, 0, 0, 0, 12'h655, 2'b11, 0, "R9 unlocked then dropped");

    // R10: permission codes
    ctl(2'd0, 2'd2, 12'h0A0, 12'h010, 2'b00);
    lookup(32'h0A00_0000, 0, 0, 1, 12'h010, 2'b00, 1, "R10 code00 priv read");
    ctl(2'd0, 2'd3, 12'h0B0, 12'h020, 2'b01);
    lookup(32'h0B00_0000, 1, 0, 1, 12'h020, 2'b01, 1, "R10 code01 user read");
    lookup(32'h0B00_0000, 0, 1, 1, 12'h020, 2'b01, 0, "R10 code01 priv write");
    ctl(2'd0, 2'd3, 12'h0B0, 12'h020, 2'b10);
    lookup(32'h0B00_0000, 1, 1, 1, 12'h020, 2'b10, 1, "R10 code10 user write");
    lookup(32'h0B00_0000, 1, 0, 1, 12'h020, 2'b10, 0, "R10 code10 user read");
    ctl(2'd0, 2'd3, 12'h0B0, 12'h020, 2'b11);
    lookup(32'h0B00_0000, 1, 1, 1, 12'h020, 2'b11, 0, "R10 code11 user write");
    drain();
    walk_perm = 2'b01;
    lookup(32'h0C00_0000, 1, 0, 0, 12'h1C0, 2'b01, 1, "R10 fault on fill");
    lookup(32'h0C00_0000, 0, 0, 1, 12'h1C0, 2'b01, 0, "R10 priv hit after fill");
    drain();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 no missing response", exp_q.size(), 0);
    summary();
  end
endmodule